// File: doc/BRIEF.md
# Network Controller Command and Status Register File

This block is the host-facing register file of a network controller. The host reaches four 16-bit control and status registers through two ports. A select port chooses a register, and a data port then reads or writes the chosen one. Register 0 is the command and status word. It holds set-only command bits and sticky event flags that the host clears by writing ones. It also holds two summary bits computed from the flags, an interrupt-enable bit and the receiver and transmitter enables. Registers 1 to 3 hold plain parameters such as the address of the initialisation block.

The transmit, receive and initialisation engines report events as one-cycle pulses. The block turns these pulses into flags and derives a level interrupt from them. It also drives the enables and command levels that those engines act on. Reads are combinational from the selected register. Writes and event pulses take effect at the next clock edge.

Top module: `netc_csr_file`

## Requirements
- R1: A write on the select port keeps only the low two bits of the written value. Later data-port reads and writes go to the register with that index.
- R2: Registers 1, 2 and 3 store every written 16-bit value exactly and read it back unchanged.
- R3: After reset, register 0 reads 0x0004 (only the stop bit set), registers 1 to 3 read 0, and the select index is 0.
- R4: In register 0, bits 14 (babble), 13 (collision error), 12 (missed packet), 11 (memory error), 10 (receive interrupt), 9 (transmit interrupt) and 8 (init done) clear when a 1 is written to them. Writing 0 to them leaves them unchanged.
- R5: Each event pulse sets its flag at the next edge. The mapping is babble→14, collision→13, missed→12, memory error→11, receive done→10, transmit done→9, init done→8. A pulse takes priority over a clear written to the same flag in the same cycle.
- R6: Bit 3 (transmit demand), bit 1 (start) and bit 0 (init) can only be set by a host write; writing 0 leaves them unchanged. Setting start or init clears bit 2 (stop). A transmit-done pulse clears transmit demand unless the host sets it in the same cycle.
- R7: Writing 1 to bit 2 sets stop and clears start and init, even when the same write also sets start or init.
- R8: Bit 6 (interrupt enable) takes the written value on every write to register 0.
- R9: Bit 15 reads as the OR of bits 14, 13, 12 and 11.
- R10: Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8. The irq output equals bit 7 AND bit 6.
- R11: An init-done pulse clears init. It sets bit 5 (receiver on) to the inverse of modeRxOff and bit 4 (transmitter on) to the inverse of modeTxOff.
- R12: While memory error is set, bits 5 and 4 read 0. While stop is set, init done reads 0.
- R13: The outputs rxOn, txOn, txDemand, startCmd, initCmd and stopped always equal bits 5, 4, 3, 1, 0 and 2 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selWe | input | 1 | Write strobe for the select port |
| dataWe | input | 1 | Write strobe for the data port |
| wrData | input | 16 | Host write value, shared by both ports |
| evBabble | input | 1 | Babble event pulse |
| evCollErr | input | 1 | Collision error event pulse |
| evMissed | input | 1 | Missed packet event pulse |
| evMemErr | input | 1 | Memory error event pulse |
| evRxDone | input | 1 | Receive complete pulse |
| evTxDone | input | 1 | Transmit complete pulse |
| evInitDone | input | 1 | Initialisation complete pulse |
| modeRxOff | input | 1 | Receiver disabled by the loaded mode |
| modeTxOff | input | 1 | Transmitter disabled by the loaded mode |
| rdData | output | 16 | Contents of the selected register |
| irq | output | 1 | Level interrupt |
| rxOn | output | 1 | Receiver enable |
| txOn | output | 1 | Transmitter enable |
| txDemand | output | 1 | Transmit poll demand |
| startCmd | output | 1 | Start command level |
| initCmd | output | 1 | Init command level |
| stopped | output | 1 | Stop state |

## Verification
Two things can happen to a register 0 bit in the same clock edge: a host write to register 0 and an engine event pulse. The cases that matter are a clear-by-one write landing on a flag that is being pulsed, an init-done pulse arriving together with a stop write, and a transmit-done pulse arriving with a transmit-demand write. The bench drives these collisions on purpose in directed steps, then mixes random writes with sparse random pulses. After every edge it compares every output with a behavioural model in which the event always wins over the clear.

// File: rtl/netc_csr_pkg.sv
package netc_csr_pkg;
  localparam int CSR_W    = 16;
  // register 0 bit positions, decoded by host software
  localparam int B_ERR  = 15;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_TDMD = 3;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;
  // sticky flags occupy bits FLAG_LSB .. FLAG_LSB+N_FLAGS-1
  localparam int N_FLAGS  = 7;
  localparam int FLAG_LSB = 8;
  localparam int F_IDON = 0;
  localparam int F_TINT = 1;
  localparam int F_RINT = 2;
  localparam int F_MERR = 3;
  localparam int F_MISS = 4;
  localparam int F_CERR = 5;
  localparam int F_BABL = 6;

  typedef struct packed {
    logic               csr0We;
    logic               plainWe;
    logic [N_FLAGS-1:0] clrFlags;
    logic               setTdmd;
    logic               setStrt;
    logic               setInit;
    logic               setStop;
    logic               ieVal;
    logic [CSR_W-1:0]   wdata;
  } csrStrobe_t;
endpackage

// File: rtl/netc_csr_ctrl.sv
module netc_csr_ctrl
  import netc_csr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWe,
  input  logic             dataWe,
  input  logic [CSR_W-1:0] wrData,
  output logic [SEL_W-1:0] selIdx,
  output csrStrobe_t       strb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      selIdx <= '0;
    else if (selWe) selIdx <= wrData[SEL_W-1:0];
  end

  logic isCsr0;
  assign isCsr0 = (selIdx == '0);

  always_comb begin
    strb          = '0;
    strb.csr0We   = dataWe && isCsr0;
    strb.plainWe  = dataWe && !isCsr0;
    strb.clrFlags = strb.csr0We ? wrData[FLAG_LSB +: N_FLAGS] : '0;
    strb.setTdmd  = strb.csr0We && wrData[B_TDMD];
    strb.setStrt  = strb.csr0We && wrData[B_STRT];
    strb.setInit  = strb.csr0We && wrData[B_INIT];
    strb.setStop  = strb.csr0We && wrData[B_STOP];
    strb.ieVal    = wrData[B_INEA];
    strb.wdata    = wrData;
  end
endmodule

// File: rtl/netc_csr_dp.sv
module netc_csr_dp
  import netc_csr_pkg::*;
#(
  parameter int NUM_CSR = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  csrStrobe_t         strb,
  input  logic [SEL_W-1:0]   selIdx,
  input  logic [N_FLAGS-1:0] evFlags,
  input  logic               evTxDone,
  input  logic               evInitDone,
  input  logic               modeRxOff,
  input  logic               modeTxOff,
  output logic [CSR_W-1:0]   csr0Word,
  output logic [CSR_W-1:0]   rdData,
  output logic               irq
);
  logic [N_FLAGS-1:0] flagsQ, flagsN;
  logic ineaQ, rxonQ, txonQ, tdmdQ, stopQ, strtQ, initQ;
  logic ineaN, rxonN, txonN, tdmdN, stopN, strtN, initN;

  always_comb begin
    tdmdN = tdmdQ;
    initN = initQ;
    rxonN = rxonQ;
    txonN = txonQ;
    strtN = strtQ;
    stopN = stopQ;
    if (evTxDone) tdmdN = 1'b0;
    if (evInitDone) begin
      initN = 1'b0;
      rxonN = !modeRxOff;
      txonN = !modeTxOff;
    end
    if (strb.setTdmd) tdmdN = 1'b1;
    if (strb.setStrt) begin strtN = 1'b1; stopN = 1'b0; end
    if (strb.setInit) begin initN = 1'b1; stopN = 1'b0; end
    if (strb.setStop) begin stopN = 1'b1; strtN = 1'b0; initN = 1'b0; end
    ineaN  = strb.csr0We ? strb.ieVal : ineaQ;
    flagsN = (flagsQ & ~strb.clrFlags) | evFlags;
    if (flagsN[F_MERR]) begin rxonN = 1'b0; txonN = 1'b0; end
    if (stopN) flagsN[F_IDON] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      ineaQ  <= 1'b0;
      rxonQ  <= 1'b0;
      txonQ  <= 1'b0;
      tdmdQ  <= 1'b0;
      stopQ  <= 1'b1;
      strtQ  <= 1'b0;
      initQ  <= 1'b0;
    end else begin
      flagsQ <= flagsN;
      ineaQ  <= ineaN;
      rxonQ  <= rxonN;
      txonQ  <= txonN;
      tdmdQ  <= tdmdN;
      stopQ  <= stopN;
      strtQ  <= strtN;
      initQ  <= initN;
    end
  end

  logic errSum, intSum;
  assign errSum = flagsQ[F_BABL] | flagsQ[F_CERR] | flagsQ[F_MISS] | flagsQ[F_MERR];
  assign intSum = flagsQ[F_BABL] | flagsQ[F_MISS] | flagsQ[F_MERR] |
                  flagsQ[F_RINT] | flagsQ[F_TINT] | flagsQ[F_IDON];

  assign csr0Word = {errSum, flagsQ, intSum, ineaQ, rxonQ, txonQ,
                     tdmdQ, stopQ, strtQ, initQ};
  assign irq = intSum & ineaQ;

  logic [CSR_W-1:0] plainQ [NUM_CSR];
  for (genvar i = 0; i < NUM_CSR; i++) begin : g_plain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        plainQ[i] <= '0;
      else if ((i != 0) && strb.plainWe && (selIdx == SEL_W'(i)))
        plainQ[i] <= strb.wdata;
    end
  end

  assign rdData = (selIdx == '0) ? csr0Word : plainQ[selIdx];
endmodule

// File: rtl/netc_csr_file.sv
module netc_csr_file
  import netc_csr_pkg::*;
#(
  parameter int NUM_CSR = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWe,
  input  logic             dataWe,
  input  logic [CSR_W-1:0] wrData,
  input  logic             evBabble,
  input  logic             evCollErr,
  input  logic             evMissed,
  input  logic             evMemErr,
  input  logic             evRxDone,
  input  logic             evTxDone,
  input  logic             evInitDone,
  input  logic             modeRxOff,
  input  logic             modeTxOff,
  output logic [CSR_W-1:0] rdData,
  output logic             irq,
  output logic             rxOn,
  output logic             txOn,
  output logic             txDemand,
  output logic             startCmd,
  output logic             initCmd,
  output logic             stopped
);
  localparam int SEL_W = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1;

  logic [SEL_W-1:0]   selIdx;
  csrStrobe_t         strb;
  logic [CSR_W-1:0]   csr0Word;
  logic [N_FLAGS-1:0] evFlags;

  assign evFlags = {evBabble, evCollErr, evMissed, evMemErr,
                    evRxDone, evTxDone, evInitDone};

  netc_csr_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selWe(selWe), .dataWe(dataWe),
    .wrData(wrData), .selIdx(selIdx), .strb(strb)
  );

  netc_csr_dp #(.NUM_CSR(NUM_CSR), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .selIdx(selIdx),
    .evFlags(evFlags), .evTxDone(evTxDone), .evInitDone(evInitDone),
    .modeRxOff(modeRxOff), .modeTxOff(modeTxOff),
    .csr0Word(csr0Word), .rdData(rdData), .irq(irq)
  );

  assign rxOn     = csr0Word[B_RXON];
  assign txOn     = csr0Word[B_TXON];
  assign txDemand = csr0Word[B_TDMD];
  assign startCmd = csr0Word[B_STRT];
  assign initCmd  = csr0Word[B_INIT];
  assign stopped  = csr0Word[B_STOP];
endmodule

// File: rtl/netc_csr_chk.sv
module netc_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stopWrite,
  input logic        tdmdWrite,
  input logic        evBabble,
  input logic [15:0] csr0Word,
  input logic        irq
);
  // R5
  babble_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    evBabble |=> csr0Word[14]);
  // R7
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopWrite |=> (csr0Word[2] && !csr0Word[1] && !csr0Word[0]));
  // R6
  tdmd_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tdmdWrite |=> csr0Word[3]);
  // R9
  err_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|csr0Word[14:11]) |-> csr0Word[15]);
  // R10
  intr_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|csr0Word[10:8]) |-> csr0Word[7]);
  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (csr0Word[6] && csr0Word[7]));
  // R12
  merr_kills_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    csr0Word[11] |-> (!csr0Word[5] && !csr0Word[4]));
  // R12
  stop_hides_idon_chk: assert property (@(posedge clk) disable iff (!rstN)
    csr0Word[2] |-> !csr0Word[8]);
endmodule

bind netc_csr_file netc_csr_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .stopWrite(dataWe && (selIdx == '0) && wrData[2]),
  .tdmdWrite(dataWe && (selIdx == '0) && wrData[3]),
  .evBabble(evBabble),
  .csr0Word(csr0Word),
  .irq(irq)
);

// File: tb/netc_csr_file_test.sv
module netc_csr_file_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        selWe = 1'b0, dataWe = 1'b0;
  logic [15:0] wrData = '0;
  logic [6:0]  evVec = '0; // {babble, coll, missed, memerr, rxdone, txdone, initdone}
  logic        modeRxOff = 1'b0, modeTxOff = 1'b0;
  logic [15:0] rdData;
  logic        irq, rxOn, txOn, txDemand, startCmd, initCmd, stopped;

  netc_csr_file uut (
    .clk(clk), .rstN(rstN), .selWe(selWe), .dataWe(dataWe), .wrData(wrData),
    .evBabble(evVec[6]), .evCollErr(evVec[5]), .evMissed(evVec[4]),
    .evMemErr(evVec[3]), .evRxDone(evVec[2]), .evTxDone(evVec[1]),
    .evInitDone(evVec[0]), .modeRxOff(modeRxOff), .modeTxOff(modeTxOff),
    .rdData(rdData), .irq(irq), .rxOn(rxOn), .txOn(txOn),
    .txDemand(txDemand), .startCmd(startCmd), .initCmd(initCmd),
    .stopped(stopped)
  );

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // behavioural model
  logic [6:0]  mFlag = '0; // index 6 babble ... 0 init done
  bit mInea = 0, mRx = 0, mTx = 0, mTdmd = 0, mStop = 1, mStrt = 0, mInit = 0;
  int mSel = 0;
  logic [15:0] mPlain [4] = '{default: 16'h0};

  function automatic logic [15:0] mCsr0();
    bit err, intr;
    err  = mFlag[6] | mFlag[5] | mFlag[4] | mFlag[3];
    intr = mFlag[6] | mFlag[4] | mFlag[3] | mFlag[2] | mFlag[1] | mFlag[0];
    return {err, mFlag, intr, mInea, mRx, mTx, mTdmd, mStop, mStrt, mInit};
  endfunction

  function automatic logic [15:0] mRead();
    return (mSel == 0) ? mCsr0() : mPlain[mSel];
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic applyModel();
    if (evVec[0]) begin mInit = 0; mRx = !modeRxOff; mTx = !modeTxOff; end
    if (evVec[1]) mTdmd = 0;
    if (dataWe) begin
      if (mSel == 0) begin
        mFlag = mFlag & ~wrData[14:8];
        if (wrData[3]) mTdmd = 1;
        if (wrData[1]) begin mStrt = 1; mStop = 0; end
        if (wrData[0]) begin mInit = 1; mStop = 0; end
        if (wrData[2]) begin mStop = 1; mStrt = 0; mInit = 0; end
        mInea = wrData[6];
      end else begin
        mPlain[mSel] = wrData;
      end
    end
    mFlag = mFlag | evVec;
    if (mFlag[3]) begin mRx = 0; mTx = 0; end
    if (mStop) mFlag[0] = 1'b0;
    if (selWe) mSel = int'(wrData[1:0]);
  endtask

  task automatic compareAll(string tag);
    logic [15:0] c0;
    c0 = mCsr0();
    chk(tag, "rdData", rdData, mRead());
    chk("R10", "irq", {15'd0, irq}, {15'd0, c0[7] & c0[6]});
    chk("R13", "ctl", {10'd0, rxOn, txOn, txDemand, stopped, startCmd, initCmd},
        {10'd0, c0[5], c0[4], c0[3], c0[2], c0[1], c0[0]});
  endtask

  task automatic step(string tag);
    @(posedge clk);
    applyModel();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic wrSel(string tag, logic [15:0] v);
    selWe = 1; wrData = v; step(tag); selWe = 0;
  endtask

  task automatic wrReg(string tag, logic [15:0] v);
    dataWe = 1; wrData = v; step(tag); dataWe = 0;
  endtask

  task automatic pulse(string tag, logic [6:0] ev);
    evVec = ev; step(tag); evVec = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3", "rdData in reset", rdData, 16'h0004);
    rstN = 1;
    @(negedge clk);
    chk("R3", "csr0 after reset", rdData, 16'h0004);
    compareAll("R3");
    wrSel("R3", 16'd1);
    wrSel("R3", 16'd2);
    wrSel("R3", 16'd3);

    // R1 select keeps low two bits; R2 plain registers
    wrSel("R1", 16'd1);
    wrReg("R2", 16'h1234);
    wrSel("R1", 16'h0005);
    chk("R1", "sel 5 -> csr1", rdData, 16'h1234);
    wrSel("R1", 16'hFFF6);
    wrReg("R2", 16'hBEEF);
    wrSel("R1", 16'h0007);
    wrReg("R2", 16'h5A5A);
    wrSel("R1", 16'h0002);
    chk("R2", "csr2 readback", rdData, 16'hBEEF);
    wrSel("R1", 16'h0000);

    // R6 set-only commands
    wrReg("R6", 16'h0002);
    wrReg("R6", 16'h0000);
    chk("R6", "start held after 0 write", {15'd0, startCmd}, 16'd1);
    wrReg("R6", 16'h0008);
    pulse("R6", 7'b0000010);
    // transmit done together with a new demand: demand wins
    evVec = 7'b0000010; wrReg("R6", 16'h0208); evVec = '0;

    // R7 stop wins
    wrReg("R7", 16'h0007);
    chk("R7", "stop only", rdData & 16'h0007, 16'h0004);

    // R11 init done
    wrReg("R11", 16'h0001);
    modeRxOff = 0; modeTxOff = 1;
    pulse("R11", 7'b0000001);
    modeTxOff = 0;
    // init done arriving with a stop write: idon must read 0
    evVec = 7'b0000001; wrReg("R12", 16'h0004); evVec = '0;
    wrReg("R11", 16'h0001);
    pulse("R11", 7'b0000001);

    // R5 / R4 flags
    pulse("R5", 7'b1110110);
    chk("R9", "err summary", {15'd0, rdData[15]}, 16'd1);
    evVec = 7'b1000000; wrReg("R5", 16'h7F00); evVec = '0;
    chk("R5", "babble survives clear", {15'd0, rdData[14]}, 16'd1);
    wrReg("R4", 16'h4000);
    chk("R4", "all flags clear", rdData & 16'hFF80, 16'h0000);

    // R8 / R10 interrupt enable
    pulse("R10", 7'b0000100);
    wrReg("R8", 16'h0040);
    chk("R10", "irq on", {15'd0, irq}, 16'd1);
    wrReg("R8", 16'h0400);
    chk("R8", "irq off", {15'd0, irq}, 16'd0);

    // R12 memory error and stop
    wrReg("R12", 16'h0001);
    pulse("R12", 7'b0000001);
    pulse("R12", 7'b0001000);
    chk("R12", "enables dropped", {14'd0, rxOn, txOn}, 16'd0);
    pulse("R12", 7'b0000001);
    wrReg("R12", 16'h0804);
    pulse("R12", 7'b0000001);
    chk("R12", "idon hidden by stop", {15'd0, rdData[8]}, 16'd0);

    // mixed random traffic with collisions
    for (int i = 0; i < 4000; i++) begin
      selWe     = ($urandom % 8) == 0;
      dataWe    = ($urandom % 3) == 0;
      wrData    = 16'($urandom);
      evVec     = 7'($urandom & $urandom & $urandom);
      modeRxOff = $urandom % 2;
      modeTxOff = $urandom % 2;
      step("R5");
    end
    selWe = 0; dataWe = 0; evVec = '0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule